// File: doc/BRIEF.md
# Configurable CAN Timeout Down-Counter

This block is the timeout watchdog of a CAN controller. A 16-bit counter is loaded with a programmable period and counts down by one on each tick input. When it reaches zero, a sticky interrupt flag is raised. Software sets the period, an enable and a source select through a 32-bit configuration word. That word can only be changed while the controller's configuration-change-enable and init control bits are both asserted. The integration supplies those two bits as inputs.

The source select decides what restarts the count. In continuous mode, software restarts it by writing the counter-value register. In the three FIFO-controlled modes, one FIFO drives the counter: the transmit event FIFO, receive FIFO 0 or receive FIFO 1. The counter is held at the period while that FIFO is empty. It starts counting down when the first element is stored into it.

The sequencing is done by a four-state machine:
- `ST_OFF`: the counter is disabled.
- `ST_ARMED`: the counter is held at the period and waits for a first-store event.
- `ST_RUN`: the counter decrements on each tick.
- `ST_DONE`: the counter has expired and holds at zero.

The transitions are:
- `cfg_load`: an accepted configuration write. It enters `ST_OFF`, `ST_ARMED` or `ST_RUN` according to the new word.
- `disable`: leads to `ST_OFF`.
- `sw_restart`: a counter-value write in continuous mode. It leads to `ST_RUN`.
- `fifo_empty_hold`: leads to `ST_ARMED`.
- `first_store`: leads from `ST_ARMED` to `ST_RUN`.
- `expire`: leads from `ST_RUN` to `ST_DONE` when a tick meets a count of 0 or 1.

Top module: `can_tmo_counter`

## Requirements
- R1: After reset, reading offset 0x28 returns 0xFFFF0000, reading offset 0x2C returns 0x0000FFFF and the timeout flag reads 0.
- R2: The configuration word at offset 0x28 has these fields:
  - bits 31:16 hold the period;
  - bits 2:1 select the source: 0 = continuous, 1 = transmit event FIFO (FIFO index 0), 2 = receive FIFO 0 (index 1), 3 = receive FIFO 1 (index 2);
  - bit 0 is the enable;
  - bits 15:3 always read 0 and ignore written values.
- R3: A write to 0x28 takes effect only when `cfg_chg_en` and `init_active` are both 1. Otherwise it leaves the word unchanged.
- R4: An accepted configuration write loads the new period into the counter at the same edge.
- R5: While the enable is 0, the counter holds the period and ignores ticks.
- R6: In continuous mode with the enable set, any write to 0x2C reloads the period and counting continues from it. In FIFO-controlled modes, or while disabled, such a write has no effect.
- R7: In a FIFO-controlled mode, the counter is held at the period while the selected FIFO's empty flag is 1. This takes precedence over ticks and store events. The empty flags of non-selected FIFOs have no effect.
- R8: In a FIFO-controlled mode, after being held, the counter starts down-counting only on a first-store pulse from the selected FIFO. A tick in the same cycle as that pulse does not decrement.
- R9: While running, each tick lowers the count by exactly one. The count saturates at 0 and never wraps.
- R10: The timeout flag is set in the cycle the count reaches 0 and stays set. Writing 1 to bit 0 of offset 0x30 clears it, writing 0 there does not, and a set in the same cycle wins over a clear.
- R11: Reading 0x2C returns the count in bits 15:0 with 0 above. Reading 0x30 returns the flag in bit 0. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cfg_chg_en | input | 1 | Configuration-change-enable bit from the control register |
| init_active | input | 1 | Init bit from the control register |
| tick | input | 1 | Count enable pulse |
| fifo_empty | input | 3 | Empty flags: [0] transmit event, [1] receive 0, [2] receive 1 |
| fifo_first_store | input | 3 | First-element-stored pulses, same bit order |
| tmo_count | output | 16 | Current counter value |
| tmo_irq | output | 1 | Sticky timeout flag |

## Verification
Directed sequences check the lock, the reserved bits, continuous restart, the expiry and saturation, and the clearing of the flag. The FIFO modes are tried with three patterns:
- the selected FIFO empty, which separates holding from counting;
- a non-selected FIFO empty, which shows that source selection is honoured;
- a first-store pulse coinciding with a tick, which separates arming from decrementing.

A seeded random phase then mixes configuration writes, with the lock open or closed, and small periods with frequent ticks, random empty flags and random store pulses. Every cycle it compares the count, the flag and the read data against a bench model. This covers expiry in all four modes and the collisions between set and clear, and between reload and tick.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int NUM_FIFO = 3;
    localparam int SRC_W  = $clog2(NUM_FIFO + 1);

    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 8'h30;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } tmo_state_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_CONT = 2'd0,
        SRC_TXEV = 2'd1,
        SRC_RX0  = 2'd2,
        SRC_RX1  = 2'd3
    } tmo_src_e;
endpackage

// File: rtl/tmo_cfg_reg.sv
module tmo_cfg_reg
    import tmo_pkg::*;
#(
    parameter int PER_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cce,
    input  logic              init,
    output logic              cfg_accept,
    output logic [PER_W-1:0]  period,
    output logic [SRC_W-1:0]  src,
    output logic              enable
);
    localparam logic [PER_W-1:0] RST_PERIOD = {PER_W{1'b1}};

    assign cfg_accept = wr_hit && cce && init;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= RST_PERIOD;
            src    <= SRC_CONT;
            enable <= 1'b0;
        end else if (cfg_accept) begin
            period <= wdata[DATA_W-1 -: PER_W];
            src    <= wdata[SRC_W:1];
            enable <= wdata[0];
        end
    end

    // R3: a locked write leaves the configuration untouched
    a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !(cce && init)) |=> ($stable(period) && $stable(src) && $stable(enable)));

    // R2: the period field comes from the upper half, independent of reserved bits
    a_r2_period_field: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_accept && (wdata[15:3] != 13'd0)) |=> (period == $past(wdata[31:16])));
endmodule

// File: rtl/tmo_src_sel.sv
module tmo_src_sel
    import tmo_pkg::*;
#(
    parameter int FIFOS = NUM_FIFO
) (
    input  logic [SRC_W-1:0] src,
    input  logic [FIFOS-1:0] fifo_empty,
    input  logic [FIFOS-1:0] fifo_first,
    output logic             fifo_mode,
    output logic             sel_empty,
    output logic             sel_first
);
    logic [FIFOS-1:0] hit;

    for (genvar i = 0; i < FIFOS; i++) begin : g_hit
        assign hit[i] = (src == SRC_W'(i + 1));
    end

    assign fifo_mode = (src != SRC_CONT);
    assign sel_empty = |(hit & fifo_empty);
    assign sel_first = |(hit & fifo_first);

    always_comb begin
        a_r7_one_source: assert ($onehot0(hit));
    end
endmodule

// File: rtl/tmo_count_fsm.sv
module tmo_count_fsm
    import tmo_pkg::*;
#(
    parameter int PER_W = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_accept,
    input  logic [PER_W-1:0] nxt_period,
    input  logic             nxt_en,
    input  logic             nxt_fifo,
    input  logic [PER_W-1:0] period,
    input  logic             enable,
    input  logic             fifo_mode,
    input  logic             cnt_wr,
    input  logic             tick,
    input  logic             sel_empty,
    input  logic             sel_first,
    output logic [PER_W-1:0] count,
    output logic             expire
);
    localparam logic [PER_W-1:0] RST_PERIOD = {PER_W{1'b1}};
    localparam logic [PER_W-1:0] ONE        = PER_W'(1);

    tmo_state_e       st, st_n;
    logic [PER_W-1:0] cnt_n;
    logic             reload_sw, hold_empty;

    assign reload_sw  = !fifo_mode && cnt_wr;
    assign hold_empty = fifo_mode && sel_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_OFF;
            count <= RST_PERIOD;
        end else begin
            st    <= st_n;
            count <= cnt_n;
        end
    end

    always_comb begin
        st_n   = st;
        cnt_n  = count;
        expire = 1'b0;
        if (cfg_accept) begin
            cnt_n = nxt_period;
            if (!nxt_en)       st_n = ST_OFF;
            else if (nxt_fifo) st_n = ST_ARMED;
            else               st_n = ST_RUN;
        end else if (!enable) begin
            st_n  = ST_OFF;
            cnt_n = period;
        end else if (reload_sw) begin
            st_n  = ST_RUN;
            cnt_n = period;
        end else if (hold_empty) begin
            st_n  = ST_ARMED;
            cnt_n = period;
        end else begin
            unique case (st)
                ST_OFF: begin
                    st_n = ST_OFF;
                end
                ST_ARMED: begin
                    if (fifo_mode && sel_first) st_n = ST_RUN;
                end
                ST_RUN: begin
                    if (tick) begin
                        if (count <= ONE) begin
                            cnt_n  = '0;
                            st_n   = ST_DONE;
                            expire = 1'b1;
                        end else begin
                            cnt_n = count - ONE;
                        end
                    end
                end
                ST_DONE: begin
                    cnt_n = '0;
                end
            endcase
        end
    end

    // R9: a tick in the running state lowers the count by one
    a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && tick && enable && !cfg_accept && !reload_sw && !hold_empty && count > ONE)
        |=> (count == $past(count) - ONE));

    // R9: once expired the count stays at zero without a reload
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && enable && !cfg_accept && !reload_sw && !hold_empty) |=> (count == '0));

    // R5: disabled counter holds the period
    a_r5_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !cfg_accept) |=> (count == $past(period)));

    // R8: an armed counter sits at the period
    a_r8_armed_at_period: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED) |-> (count == period));
endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (expire) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // R10: flag is sticky until a clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R10: expiry always leaves the flag set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
endmodule

// File: rtl/can_tmo_counter.sv
module can_tmo_counter
    import tmo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                cfg_chg_en,
    input  logic                init_active,
    input  logic                tick,
    input  logic [NUM_FIFO-1:0] fifo_empty,
    input  logic [NUM_FIFO-1:0] fifo_first_store,
    output logic [CNT_W-1:0]    tmo_count,
    output logic                tmo_irq
);
    localparam int RSV_W = DATA_W - CNT_W - SRC_W - 1;

    logic             cfg_hit, cnt_hit, flag_hit;
    logic             cfg_accept, enable, fifo_mode, sel_empty, sel_first, expire;
    logic [CNT_W-1:0] period;
    logic [SRC_W-1:0] src;

    assign cfg_hit  = reg_we && (reg_addr == OFS_CFG);
    assign cnt_hit  = reg_we && (reg_addr == OFS_CNT);
    assign flag_hit = reg_we && (reg_addr == OFS_FLAG);

    tmo_cfg_reg #(.PER_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_hit(cfg_hit), .wdata(reg_wdata),
        .cce(cfg_chg_en), .init(init_active), .cfg_accept(cfg_accept),
        .period(period), .src(src), .enable(enable)
    );

    tmo_src_sel #(.FIFOS(NUM_FIFO)) u_sel (
        .src(src), .fifo_empty(fifo_empty), .fifo_first(fifo_first_store),
        .fifo_mode(fifo_mode), .sel_empty(sel_empty), .sel_first(sel_first)
    );

    tmo_count_fsm #(.PER_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_accept(cfg_accept),
        .nxt_period(reg_wdata[DATA_W-1 -: CNT_W]), .nxt_en(reg_wdata[0]),
        .nxt_fifo(reg_wdata[SRC_W:1] != SRC_CONT),
        .period(period), .enable(enable), .fifo_mode(fifo_mode),
        .cnt_wr(cnt_hit), .tick(tick), .sel_empty(sel_empty), .sel_first(sel_first),
        .count(tmo_count), .expire(expire)
    );

    tmo_flag u_flag (
        .clk(clk), .rst_n(rst_n), .expire(expire),
        .clr(flag_hit && reg_wdata[0]), .flag(tmo_irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_CFG:  reg_rdata = {period, {RSV_W{1'b0}}, src, enable};
            OFS_CNT:  reg_rdata = {{(DATA_W-CNT_W){1'b0}}, tmo_count};
            OFS_FLAG: reg_rdata = {{(DATA_W-1){1'b0}}, tmo_irq};
            default:  reg_rdata = '0;
        endcase
    end

    // R6: a counter-value write outside continuous mode leaves the count alone
    a_r6_fifo_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hit && fifo_mode && enable && !cfg_accept && !sel_empty && !tick) |=> $stable(tmo_count));
endmodule

// File: tb/can_tmo_counter_tb.sv
`timescale 1ns/1ps
module can_tmo_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        cfg_chg_en = 1'b1;
    logic        init_active = 1'b1;
    logic        tick = 1'b0;
    logic [2:0]  fifo_empty = 3'b000;
    logic [2:0]  fifo_first_store = 3'b000;
    logic [15:0] tmo_count;
    logic        tmo_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    can_tmo_counter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_chg_en(cfg_chg_en),
        .init_active(init_active), .tick(tick), .fifo_empty(fifo_empty),
        .fifo_first_store(fifo_first_store), .tmo_count(tmo_count), .tmo_irq(tmo_irq)
    );

    // reference model built from the requirements
    logic [15:0] m_top = 16'hFFFF;
    logic [1:0]  m_mode = 2'd0;
    logic        m_en = 1'b0;
    logic [15:0] m_cnt = 16'hFFFF;
    logic        m_flag = 1'b0;
    int          m_ph = 0; // 0 off, 1 held, 2 counting, 3 expired

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_top = 16'hFFFF; m_mode = 2'd0; m_en = 1'b0;
            m_cnt = 16'hFFFF; m_flag = 1'b0; m_ph = 0;
        end else begin
            logic hit, sel_e, sel_f, exp_now;
            exp_now = 1'b0;
            sel_e = (m_mode != 0) && fifo_empty[m_mode - 2'd1];
            sel_f = (m_mode != 0) && fifo_first_store[m_mode - 2'd1];
            hit = reg_we && reg_addr == 8'h28 && cfg_chg_en && init_active;
            if (hit) begin
                m_top = reg_wdata[31:16]; m_mode = reg_wdata[2:1]; m_en = reg_wdata[0];
                m_cnt = m_top;
                m_ph = !m_en ? 0 : (m_mode != 0 ? 1 : 2);
            end else if (!m_en) begin
                m_cnt = m_top; m_ph = 0;
            end else if (m_mode == 0 && reg_we && reg_addr == 8'h2C) begin
                m_cnt = m_top; m_ph = 2;
            end else if (sel_e) begin
                m_cnt = m_top; m_ph = 1;
            end else if (m_ph == 1 && sel_f) begin
                m_ph = 2;
            end else if (m_ph == 2 && tick) begin
                if (m_cnt <= 16'd1) begin m_cnt = 16'd0; m_ph = 3; exp_now = 1'b1; end
                else m_cnt = m_cnt - 16'd1;
            end
            if (exp_now) m_flag = 1'b1;
            else if (reg_we && reg_addr == 8'h30 && reg_wdata[0]) m_flag = 1'b0;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h28:   return {m_top, 13'd0, m_mode, m_en};
            8'h2C:   return {16'd0, m_cnt};
            8'h30:   return {31'd0, m_flag};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a; #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1 cfg", 8'h28, 32'hFFFF0000);
        rd("R1 cnt", 8'h2C, 32'h0000FFFF);
        rd("R1 flag", 8'h30, 32'h0);
        // R3 locked writes
        cfg_chg_en = 1'b0;
        wr(8'h28, 32'h00050003);
        rd("R3 cce low", 8'h28, 32'hFFFF0000);
        cfg_chg_en = 1'b1; init_active = 1'b0;
        wr(8'h28, 32'h00050003);
        rd("R3 init low", 8'h28, 32'hFFFF0000);
        init_active = 1'b1;
        // R2 reserved bits, R4 load on write, continuous mode
        wr(8'h28, 32'h0005FFF9);
        rd("R2 layout", 8'h28, 32'h00050001);
        chk("R4 loaded", {16'd0, tmo_count}, 32'd5);
        ticks(3);
        chk("R9 step", {16'd0, tmo_count}, 32'd2);
        wr(8'h2C, 32'h0);
        chk("R6 reload", {16'd0, tmo_count}, 32'd5);
        ticks(5);
        chk("R9 zero", {16'd0, tmo_count}, 32'd0);
        chk("R10 set", {31'd0, tmo_irq}, 32'd1);
        ticks(2);
        chk("R9 saturate", {16'd0, tmo_count}, 32'd0);
        wr(8'h30, 32'h0);
        rd("R10 zero write", 8'h30, 32'd1);
        wr(8'h30, 32'h1);
        rd("R10 clear", 8'h30, 32'd0);
        // R5 disabled
        wr(8'h28, 32'h00070000);
        ticks(3);
        chk("R5 hold", {16'd0, tmo_count}, 32'd7);
        wr(8'h2C, 32'h0);
        chk("R6 ignored when off", {16'd0, tmo_count}, 32'd7);
        // R7 / R8 receive FIFO 0 (mode 2, index 1)
        fifo_empty = 3'b010;
        wr(8'h28, 32'h00040005);
        ticks(2);
        chk("R7 held", {16'd0, tmo_count}, 32'd4);
        fifo_empty = 3'b000;
        ticks(2);
        chk("R8 waits for store", {16'd0, tmo_count}, 32'd4);
        @(negedge clk); fifo_first_store = 3'b010; tick = 1'b1;
        @(negedge clk); fifo_first_store = 3'b000; tick = 1'b0;
        chk("R8 start no step", {16'd0, tmo_count}, 32'd4);
        ticks(1);
        fifo_empty = 3'b101;
        ticks(1);
        chk("R7 other empty ignored", {16'd0, tmo_count}, 32'd2);
        wr(8'h2C, 32'h0);
        chk("R6 ignored in fifo mode", {16'd0, tmo_count}, 32'd2);
        fifo_empty = 3'b010;
        ticks(1);
        chk("R7 re-held", {16'd0, tmo_count}, 32'd4);
        rd("R11 other ofs", 8'h34, 32'd0);
        rd("R11 cnt ofs", 8'h2C, 32'd4);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            #0.5;
            chk("R4,R5,R6,R7,R8,R9 count", {16'd0, tmo_count}, {16'd0, m_cnt});
            chk("R10 flag", {31'd0, tmo_irq}, {31'd0, m_flag});
            chk("R2,R11 read", reg_rdata, exp_rd(reg_addr));
            reg_we = ($urandom_range(0, 99) < 15);
            case ($urandom_range(0, 3))
                0: reg_addr = 8'h28;
                1: reg_addr = 8'h2C;
                2: reg_addr = 8'h30;
                default: reg_addr = 8'h34;
            endcase
            reg_wdata = {16'($urandom_range(0, 10)), 16'($urandom)};
            cfg_chg_en = ($urandom_range(0, 99) < 85);
            init_active = ($urandom_range(0, 99) < 85);
            tick = ($urandom_range(0, 99) < 60);
            for (int f = 0; f < 3; f++) begin
                if ($urandom_range(0, 99) < 5) fifo_empty[f] = ~fifo_empty[f];
                fifo_first_store[f] = ($urandom_range(0, 99) < 8);
            end
        end
        summary();
        $finish;
    end
endmodule